// File: doc/BRIEF.md
# Register Write-Reservation Hazard Scoreboard

This block sits beside the issue stage of an in-order pipeline. It holds, for every architectural register, a count of older in-flight instructions that still owe a write to it. Each cycle the instruction offered for issue is compared against that state. Any conflict raises a flag for its hazard class and a combined stall, and a stalled instruction leaves no trace in the scoreboard.

Three hazard classes are detected. A read-after-write hazard occurs when a source of the issuing instruction still has a pending write. A write-after-write hazard occurs when its destination still has a pending write. A write-after-read hazard occurs when its destination is still to be read by an older instruction; the pipeline supplies that set as a per-register mask. An accepted instruction reserves its destination. Each completion releases one reservation, and a completion in the same cycle as an issue is taken into account before the issue is checked. Index 0 stands for "no register". A parameter turns the write-after-write check off, for pipelines that retire writes in order; several writers to one register are then counted up to a fixed limit.

Top module: `hzd_scoreboard`

## Requirements
- R1: With `iss_valid` high, `haz_raw` is 1 when `iss_src_a` or `iss_src_b` is a nonzero index that holds a reservation which the same-cycle completion does not fully release.
- R2: With `iss_valid` high and `WAW_CHECK`=1, `haz_waw` is 1 when `iss_dst` is a nonzero index that holds such a live reservation.
- R3: With `iss_valid` high, `haz_war` is 1 when `iss_dst` is nonzero and bit `iss_dst` of `rd_pend_mask` is 1.
- R4: Index 0 is never reserved and never raises a flag, whether it appears as a source or as a destination, and whatever bit 0 of `rd_pend_mask` holds.
- R5: An issue that is accepted (`iss_valid` high, no flag) with a nonzero `iss_dst` reserves that register from the next cycle on.
- R6: A completion (`cmp_valid`, nonzero `cmp_dst`) removes one reservation from that register. The register is free once no reservation is left. A completion to a register with no reservation is ignored, so a later writer is still tracked.
- R7: When a completion and an accepted issue name the same register in one cycle, the completion does not block the issue, and the register stays reserved for the new writer.
- R8: `stall` equals `iss_valid` AND (any hazard flag). A stalled issue changes no reservation.
- R9: With `WAW_CHECK`=0, several writers to one register are accepted, and the register stays reserved until each of them has completed.
- R10: An issue whose destination already holds `MAX_WRITERS` reservations raises `haz_waw` in either mode.
- R11: After synchronous reset, no register is reserved. While `iss_valid` is low, all flags and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_src_a | input | AW | First source register index (0 = unused) |
| iss_src_b | input | AW | Second source register index (0 = unused) |
| iss_dst | input | AW | Destination register index (0 = no write) |
| cmp_valid | input | 1 | A write completes this cycle |
| cmp_dst | input | AW | Register whose write completes |
| rd_pend_mask | input | NREG | Registers that older instructions have not yet read |
| haz_raw | output | 1 | Read-after-write hazard on the offered instruction |
| haz_waw | output | 1 | Write-after-write hazard, or the reservation counter is full |
| haz_war | output | 1 | Write-after-read hazard on the offered instruction |
| stall | output | 1 | Offered instruction is held back |

## Verification
A reservation that is lost or left behind shows up on the next probe that reads the register. A lost reservation lets a dependent read through with `haz_raw` low. A stale one keeps `stall` high after the completion, and so does a counter that wrapped on a spurious completion. A counter that moves on a stalled issue shows up one completion later, when the register frees too early or too late. The bench therefore follows every reservation change with a reader probe on the next cycle. It covers the completion-bypass cases in the same cycle as the completion.

// File: rtl/hzd_pkg.sv
// Package: shared types for the hazard scoreboard.
// Assumes nothing beyond standard SystemVerilog.
package hzd_pkg;

    // Per-class hazard flags for one offered instruction.
    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
    } hzd_flags_t;

endpackage

// File: rtl/hzd_resv_bank.sv
// Module: hzd_resv_bank
// Holds one saturating-free reservation counter per register (index 0 has none).
// Reports which registers are held now, which stay held once this cycle's
// completion is applied, and which are at the counter limit.
// Assumes the caller never increments a register that reports full.
module hzd_resv_bank #(
    parameter int NREG        = 32,
    parameter int MAX_WRITERS = 3,
    localparam int AW         = $clog2(NREG),
    localparam int CW         = $clog2(MAX_WRITERS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_en,
    input  logic [AW-1:0]   inc_idx,
    input  logic            dec_en,
    input  logic [AW-1:0]   dec_idx,
    output logic [NREG-1:0] held,
    output logic [NREG-1:0] live_busy,
    output logic [NREG-1:0] full
);

    // Register 0 carries no state.
    assign held[0]      = 1'b0;
    assign live_busy[0] = 1'b0;
    assign full[0]      = 1'b0;

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        logic [CW-1:0] cnt_q;
        logic          inc_hit;
        logic          dec_hit;

        // Decode this register's increment and its (non-underflowing) decrement.
        always_comb begin
            inc_hit = inc_en && (inc_idx == AW'(r));
            dec_hit = dec_en && (dec_idx == AW'(r)) && (cnt_q != '0);
        end

        // Count pending writers; simultaneous inc and dec cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (inc_hit && !dec_hit) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (dec_hit && !inc_hit) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        // Status seen by the classifier, with the same-cycle completion applied.
        always_comb begin
            held[r]      = (cnt_q != '0);
            live_busy[r] = (cnt_q != '0) && !(dec_hit && (cnt_q == CW'(1)));
            full[r]      = (cnt_q == CW'(MAX_WRITERS)) && !dec_hit;
        end

        assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(MAX_WRITERS));

        assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_hit && !dec_hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

        assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_hit && !inc_hit) |=> (cnt_q == $past(cnt_q) - 1'b1));
    end

endmodule

// File: rtl/hzd_classify.sv
// Module: hzd_classify
// Combinational hazard classification of the offered instruction against the
// live reservation state and the pending-read mask. Index 0 never matches.
// Assumes live_busy[0] and full[0] are zero.
module hzd_classify
    import hzd_pkg::*;
#(
    parameter int NREG      = 32,
    parameter bit WAW_CHECK = 1'b1,
    localparam int AW       = $clog2(NREG)
) (
    input  logic            iss_valid,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic [AW-1:0]   dst,
    input  logic [NREG-1:0] live_busy,
    input  logic [NREG-1:0] full,
    input  logic [NREG-1:0] rd_pend,
    output hzd_flags_t      flags
);

    logic dst_used;
    logic waw_order;

    // The write-ordering check exists only in the checked variant.
    if (WAW_CHECK) begin : g_waw_on
        assign waw_order = live_busy[dst];
    end else begin : g_waw_off
        assign waw_order = 1'b0;
    end

    // Classify each hazard kind; all flags are gated by a valid offer.
    always_comb begin
        dst_used  = (dst != '0);
        flags.raw = iss_valid && ((src_a != '0 && live_busy[src_a]) ||
                                  (src_b != '0 && live_busy[src_b]));
        flags.waw = iss_valid && dst_used && (waw_order || full[dst]);
        flags.war = iss_valid && dst_used && rd_pend[dst];
    end

endmodule

// File: rtl/hzd_scoreboard.sv
// Module: hzd_scoreboard
// Issue-stage hazard scoreboard: per-register write reservations, checked
// against each offered instruction for RAW, WAW and WAR conflicts.
// Assumes one issue and one completion per cycle, and that rd_pend_mask
// lists registers that older instructions have yet to read.
module hzd_scoreboard
    import hzd_pkg::*;
#(
    parameter int NREG        = 32,
    parameter int MAX_WRITERS = 3,
    parameter bit WAW_CHECK   = 1'b1,
    localparam int AW         = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [AW-1:0]   iss_src_a,
    input  logic [AW-1:0]   iss_src_b,
    input  logic [AW-1:0]   iss_dst,
    input  logic            cmp_valid,
    input  logic [AW-1:0]   cmp_dst,
    input  logic [NREG-1:0] rd_pend_mask,
    output logic            haz_raw,
    output logic            haz_waw,
    output logic            haz_war,
    output logic            stall
);

    logic [NREG-1:0] held;
    logic [NREG-1:0] live_busy;
    logic [NREG-1:0] full;
    hzd_flags_t      flags;
    logic            accept;
    logic            inc_en;
    logic            dec_en;

    hzd_resv_bank #(
        .NREG        (NREG),
        .MAX_WRITERS (MAX_WRITERS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (inc_en),
        .inc_idx   (iss_dst),
        .dec_en    (dec_en),
        .dec_idx   (cmp_dst),
        .held      (held),
        .live_busy (live_busy),
        .full      (full)
    );

    hzd_classify #(
        .NREG      (NREG),
        .WAW_CHECK (WAW_CHECK)
    ) u_cls (
        .iss_valid (iss_valid),
        .src_a     (iss_src_a),
        .src_b     (iss_src_b),
        .dst       (iss_dst),
        .live_busy (live_busy),
        .full      (full),
        .rd_pend   (rd_pend_mask),
        .flags     (flags)
    );

    // Accept when no hazard; only accepted writers and real completions touch state.
    always_comb begin
        accept  = iss_valid && !(flags.raw || flags.waw || flags.war);
        inc_en  = accept && (iss_dst != '0);
        dec_en  = cmp_valid && (cmp_dst != '0);
        haz_raw = flags.raw;
        haz_waw = flags.waw;
        haz_war = flags.war;
        stall   = iss_valid && !accept;
    end

    assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !cmp_valid) |=> (held == $past(held)));

    assert_reserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && iss_dst != '0) |=> held[$past(iss_dst)]);

    assert_swap_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && cmp_valid && cmp_dst == iss_dst && iss_dst != '0)
        |=> held[$past(iss_dst)]);

    assert_zero_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_dst == '0) |-> (!haz_waw && !haz_war));

    assert_raw_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        haz_raw |-> (iss_src_a != '0 || iss_src_b != '0));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (!stall && !haz_raw && !haz_waw && !haz_war));

endmodule

// File: tb/test_hzd_scoreboard.sv
module test_hzd_scoreboard;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int AW   = 5;

    typedef struct packed {
        logic          iv;
        logic [AW-1:0] sa;
        logic [AW-1:0] sb;
        logic [AW-1:0] d;
        logic          cv;
        logic [AW-1:0] cd;
        logic [31:0]   mask;
        logic          raw;
        logic          waw;
        logic          war;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 5'd1,  5'd2, 5'd3,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R5 reserve r3
        '{1'b1, 5'd3,  5'd0, 5'd4,  1'b0, 5'd0,  32'h0,        1'b1, 1'b0, 1'b0}, // R1
        '{1'b1, 5'd0,  5'd0, 5'd3,  1'b0, 5'd0,  32'h0,        1'b0, 1'b1, 1'b0}, // R2
        '{1'b1, 5'd5,  5'd6, 5'd7,  1'b0, 5'd0,  32'h80,       1'b0, 1'b0, 1'b1}, // R3
        '{1'b1, 5'd5,  5'd6, 5'd7,  1'b0, 5'd0,  32'h1,        1'b0, 1'b0, 1'b0}, // R3 other bit; R8 no prior change
        '{1'b0, 5'd3,  5'd0, 5'd3,  1'b1, 5'd3,  32'h8,        1'b0, 1'b0, 1'b0}, // R11 idle flags low; R6 free r3
        '{1'b1, 5'd3,  5'd0, 5'd0,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R6 r3 free
        '{1'b1, 5'd7,  5'd0, 5'd0,  1'b1, 5'd7,  32'h0,        1'b0, 1'b0, 1'b0}, // R1 bypass of completion
        '{1'b1, 5'd7,  5'd0, 5'd0,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R6 r7 free
        '{1'b1, 5'd0,  5'd0, 5'd9,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R5 reserve r9
        '{1'b1, 5'd0,  5'd0, 5'd9,  1'b1, 5'd9,  32'h0,        1'b0, 1'b0, 1'b0}, // R7 swap
        '{1'b1, 5'd9,  5'd0, 5'd0,  1'b0, 5'd0,  32'h0,        1'b1, 1'b0, 1'b0}, // R7 still held
        '{1'b1, 5'd0,  5'd0, 5'd0,  1'b0, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}, // R4
        '{1'b1, 5'd0,  5'd9, 5'd0,  1'b0, 5'd0,  32'h0,        1'b1, 1'b0, 1'b0}, // R1 second source
        '{1'b0, 5'd0,  5'd0, 5'd0,  1'b1, 5'd9,  32'h0,        1'b0, 1'b0, 1'b0}, // R6 free r9
        '{1'b1, 5'd9,  5'd9, 5'd9,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R5 reserve r9
        '{1'b1, 5'd9,  5'd0, 5'd9,  1'b0, 5'd0,  32'h200,      1'b1, 1'b1, 1'b1}, // R1 R2 R3 together
        '{1'b0, 5'd0,  5'd0, 5'd0,  1'b1, 5'd12, 32'h0,        1'b0, 1'b0, 1'b0}, // R6 spurious completion
        '{1'b1, 5'd0,  5'd0, 5'd12, 1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R5 reserve r12
        '{1'b1, 5'd12, 5'd0, 5'd0,  1'b0, 5'd0,  32'h0,        1'b1, 1'b0, 1'b0}, // R6 no underflow
        '{1'b0, 5'd0,  5'd0, 5'd0,  1'b1, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}, // R4 completion of r0
        '{1'b1, 5'd12, 5'd0, 5'd0,  1'b1, 5'd12, 32'h0,        1'b0, 1'b0, 1'b0}, // R4 r12 kept, R1 bypass
        '{1'b1, 5'd3,  5'd7, 5'd0,  1'b0, 5'd0,  32'h0,        1'b0, 1'b0, 1'b0}  // R6 all freed
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iss_valid = 1'b0;
    logic [AW-1:0]   iss_src_a = '0;
    logic [AW-1:0]   iss_src_b = '0;
    logic [AW-1:0]   iss_dst = '0;
    logic            cmp_valid = 1'b0;
    logic [AW-1:0]   cmp_dst = '0;
    logic [NREG-1:0] rd_pend_mask = '0;
    logic            haz_raw, haz_waw, haz_war, stall;
    logic            m_raw, m_waw, m_war, m_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_scoreboard i_hzd_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .rd_pend_mask(rd_pend_mask),
        .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war), .stall(stall)
    );

    hzd_scoreboard #(.MAX_WRITERS(2), .WAW_CHECK(1'b0)) i_hzd_scoreboard_multi (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .rd_pend_mask(rd_pend_mask),
        .haz_raw(m_raw), .haz_waw(m_waw), .haz_war(m_war), .stall(m_stall)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s raw/waw/war/stall got %b expected %b", req, got, exp);
        end
    endtask

    // Drive inputs just after a falling edge, then let them settle.
    task automatic drive(input logic iv, input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic [AW-1:0] d, input logic cv, input logic [AW-1:0] cd,
                         input logic [31:0] mask);
        @(negedge clk);
        iss_valid = iv; iss_src_a = sa; iss_src_b = sb; iss_dst = d;
        cmp_valid = cv; cmp_dst = cd; rd_pend_mask = mask;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_valid = 1'b0; cmp_valid = 1'b0; rd_pend_mask = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state: nothing reserved, idle flags low
        drive(1'b0, 5'd3, 5'd3, 5'd3, 1'b0, 5'd0, 32'h0);
        chk("R11 idle", {haz_raw, haz_waw, haz_war, stall}, 4'b0000);
        drive(1'b1, 5'd3, 5'd9, 5'd0, 1'b0, 5'd0, 32'h0);
        chk("R11 reset empty", {haz_raw, haz_waw, haz_war, stall}, 4'b0000);

        // Table walk; expected stall follows R8
        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].iv, TBL[i].sa, TBL[i].sb, TBL[i].d, TBL[i].cv, TBL[i].cd, TBL[i].mask);
            chk($sformatf("R8 vector %0d", i), {haz_raw, haz_waw, haz_war, stall},
                {TBL[i].raw, TBL[i].waw, TBL[i].war,
                 TBL[i].iv & (TBL[i].raw | TBL[i].waw | TBL[i].war)});
        end

        // R11 reset clears a held reservation (r9 is held after the table)
        drive(1'b1, 5'd9, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        chk("R11 r9 held before reset", {haz_raw, haz_waw, haz_war, stall}, 4'b1001);
        do_reset();
        drive(1'b1, 5'd9, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        chk("R11 r9 free after reset", {haz_raw, haz_waw, haz_war, stall}, 4'b0000);

        // R9 / R10 counting variant (WAW check off, limit 2)
        drive(1'b1, 5'd0, 5'd0, 5'd5, 1'b0, 5'd0, 32'h0);
        chk("R9 first writer", {m_raw, m_waw, m_war, m_stall}, 4'b0000);
        drive(1'b1, 5'd0, 5'd0, 5'd5, 1'b0, 5'd0, 32'h0);
        chk("R9 second writer", {m_raw, m_waw, m_war, m_stall}, 4'b0000);
        chk("R2 checked variant blocks", {haz_raw, haz_waw, haz_war, stall}, 4'b0101);
        drive(1'b1, 5'd0, 5'd0, 5'd5, 1'b0, 5'd0, 32'h0);
        chk("R10 limit reached", {m_raw, m_waw, m_war, m_stall}, 4'b0101);
        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd5, 32'h0);
        drive(1'b1, 5'd5, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        chk("R9 one writer left", {m_raw, m_waw, m_war, m_stall}, 4'b1001);
        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd5, 32'h0);
        drive(1'b1, 5'd5, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        chk("R9 all writers done", {m_raw, m_waw, m_war, m_stall}, 4'b0000);

        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule